// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Controller

This block is a byte-level transmit engine for the master side of a shared two-wire bus on which several masters may compete. Each line is handled open-drain style: the block only ever asserts a pull-low enable, and it reads the resolved line level back. Both line levels pass through a synchronizer. The synchronized levels feed a bus monitor and the master state machine.

Software-facing control is a set of strobes: a buffer write, START, repeated START, STOP and acknowledge. Each accepted sequence raises its own enable flag until it finishes. A driven bit of '1' is sent by releasing SDA. It is then compared with the line level halfway through the SCL-high time. A mismatch, or a line held low where a START, repeated START, STOP or acknowledge expects it released, means that another master has won. When that happens the block drops both lines, flushes the pending buffer and any sequence, and sets a sticky collision flag.

The monitor keeps running after a collision. It tracks START and STOP conditions from any master into two status bits, derives a bus-free indication from them, and flags every STOP it sees. One SCL period is a fixed number of system clocks, set by a parameter.

Top module: `i2cm_arb_master`

## Requirements
- R1: Out of reset both pull-low enables are 0, buf_full, all four sequence enables, coll_irq, stop_irq, bus_s and bus_p are 0, and bus_free is 1.
- R2: A cmd_start pulse is taken only when no sequence is active and bus_free is 1. Once taken, start_en goes to 1, SDA falls while SCL stays high, SCL is then pulled low, and start_en returns to 0. A cmd_start pulse while bus_free is 0 leaves start_en at 0 and both lines released.
- R3: A wr_en pulse while buf_full is 0 stores wr_data and sets buf_full. A wr_en pulse while buf_full is 1 is ignored. After a START, the stored byte goes out MSB first, one bit per SCL pulse, with a '1' sent by releasing SDA. A ninth SCL pulse follows with SDA released. buf_full clears after that ninth pulse.
- R4: From the holding state, cmd_stop produces a STOP (SDA rises while SCL is high) and leaves both lines released. cmd_restart produces a repeated START (SDA falls while SCL is high). Their enables stop_en and rstart_en are 1 only while the sequence runs.
- R5: During a data bit whose intended value is '1', SDA sampled low halfway through SCL-high sets coll_irq. In the same cycle both lines are released and buf_full clears.
- R6: If SDA is held low where a START, repeated START, STOP or acknowledge of '1' expects it released, the sequence is aborted. Its enable clears, both lines are released and coll_irq is set.
- R7: A START (SDA falls while SCL is high) sets bus_s and clears bus_p. A STOP (SDA rises while SCL is high) sets bus_p and clears bus_s. bus_s and bus_p are never 1 together. bus_free is 1 when bus_p is 1 or both are 0.
- R8: stop_irq is set by every STOP seen on the bus, including one made by another master after a lost arbitration. stop_irq and coll_irq hold until a stop_clr or coll_clr pulse clears them.
- R9: After a collision, the next stored byte is sent from its MSB, whatever bit position the aborted byte had reached.
- R10: One SCL period lasts 4·DIV_N system clocks.
- R11: Only one sequence runs at a time. Command strobes that arrive while any enable is 1 are ignored, and at most one enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| wr_en | input | 1 | Transmit buffer write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| buf_full | output | 1 | Buffer holds a byte not yet fully sent |
| cmd_start | input | 1 | Request a START |
| cmd_restart | input | 1 | Request a repeated START |
| cmd_stop | input | 1 | Request a STOP |
| cmd_ack | input | 1 | Request an acknowledge bit |
| ack_bit | input | 1 | Value sent in the acknowledge bit |
| start_en | output | 1 | START sequence active |
| rstart_en | output | 1 | Repeated START sequence active |
| stop_en | output | 1 | STOP sequence active |
| ack_en | output | 1 | Acknowledge sequence active |
| coll_irq | output | 1 | Sticky bus collision flag |
| coll_clr | input | 1 | Clear coll_irq |
| stop_irq | output | 1 | Sticky STOP-detected flag |
| stop_clr | input | 1 | Clear stop_irq |
| bus_s | output | 1 | Last condition seen was START |
| bus_p | output | 1 | Last condition seen was STOP |
| bus_free | output | 1 | Bus may be claimed |

## Verification
A wrong phase or quarter count shows within one SCL period as a START, STOP or bit in the wrong place on the modelled lines. The scoreboard checks every condition and byte as it completes. A collision check that fires too late or not at all shows as a line still pulled low, or buf_full still set, in the cycle coll_irq rises. Broken S/P bookkeeping shows a few clocks after a condition from the other master, as a wrong bus_free or a START that is taken or refused in error.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HOLD,
      PH_START,
      PH_RSTART,
      PH_DATA,
      PH_ACK,
      PH_STOP
   } phase_e;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg <= '1;
            end else begin
               stg[0] <= din;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign dout = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2cm_cond_det.sv
module i2cm_cond_det (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_det,
   output logic stop_det,
   output logic bus_s,
   output logic bus_p
);
   logic scl_q, sda_q;

   // conditions only count when SCL is high before and after the SDA edge
   assign start_det = scl_q & scl_s & sda_q & ~sda_s;
   assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
         bus_s <= 1'b0;
         bus_p <= 1'b0;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         if (start_det) begin
            bus_s <= 1'b1;
            bus_p <= 1'b0;
         end else if (stop_det) begin
            bus_s <= 1'b0;
            bus_p <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/i2cm_xmit.sv
module i2cm_xmit
   import i2cm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_N  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              bus_free,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cmd_start,
   input  logic              cmd_restart,
   input  logic              cmd_stop,
   input  logic              cmd_ack,
   input  logic              ack_bit,
   output logic              scl_low,
   output logic              sda_low,
   output logic              buf_full,
   output logic              start_en,
   output logic              rstart_en,
   output logic              stop_en,
   output logic              ack_en,
   output logic              coll
);
   localparam int QW = (DIV_N > 1) ? $clog2(DIV_N) : 1;
   localparam int BW = $clog2(DATA_W + 1);
   localparam logic [QW-1:0] QLAST = QW'(DIV_N - 1);
   localparam logic [BW-1:0] BLAST = BW'(DATA_W);

   phase_e            ph;
   logic [1:0]        qidx;
   logic [QW-1:0]     qcnt;
   logic [BW-1:0]     bidx;
   logic [DATA_W-1:0] shreg, hold_q;
   logic              bf_q, ack_q;
   logic [3:0]        en_q;   // ack, stop, restart, start
   logic              tick, cur_bit;

   assign tick    = (qcnt == QLAST);
   assign cur_bit = (bidx == BLAST) ? 1'b1 : shreg[DATA_W-1];

   // line drive per phase and quarter of the SCL period
   always_comb begin
      scl_low = 1'b0;
      sda_low = 1'b0;
      case (ph)
         PH_HOLD:   scl_low = 1'b1;
         PH_START:  begin scl_low = (qidx == 2'd3); sda_low = qidx[1]; end
         PH_RSTART: begin scl_low = (qidx == 2'd0) || (qidx == 2'd3); sda_low = qidx[1]; end
         PH_DATA:   begin scl_low = ~qidx[1]; sda_low = ~cur_bit; end
         PH_ACK:    begin scl_low = ~qidx[1]; sda_low = ~ack_q; end
         PH_STOP:   begin scl_low = (qidx == 2'd0); sda_low = ~qidx[1]; end
         default:   ;
      endcase
   end

   // compare released SDA with the line at the check point of each phase
   always_comb begin
      coll = 1'b0;
      case (ph)
         PH_START, PH_RSTART: coll = tick && (qidx == 2'd1) && !sda_s;
         PH_DATA:  coll = tick && (qidx == 2'd2) && (bidx != BLAST) && shreg[DATA_W-1] && !sda_s;
         PH_ACK:   coll = tick && (qidx == 2'd2) && ack_q && !sda_s;
         PH_STOP:  coll = tick && (qidx == 2'd3) && !sda_s;
         default:  coll = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         qidx   <= '0;
         qcnt   <= '0;
         bidx   <= '0;
         shreg  <= '0;
         hold_q <= '0;
         bf_q   <= 1'b0;
         ack_q  <= 1'b1;
         en_q   <= '0;
      end else if (coll) begin
         ph   <= PH_IDLE;
         qidx <= '0;
         qcnt <= '0;
         en_q <= '0;
         bf_q <= 1'b0;
      end else begin
         if (wr_en && !bf_q) begin
            hold_q <= wr_data;
            bf_q   <= 1'b1;
         end
         case (ph)
            PH_IDLE: begin
               if (cmd_start && bus_free) begin
                  en_q <= 4'b0001;
                  ph   <= PH_START;
               end
            end
            PH_HOLD: begin
               if (bf_q) begin
                  ph    <= PH_DATA;
                  shreg <= hold_q;
                  bidx  <= '0;
               end else if (cmd_restart) begin
                  en_q <= 4'b0010;
                  ph   <= PH_RSTART;
               end else if (cmd_stop) begin
                  en_q <= 4'b0100;
                  ph   <= PH_STOP;
               end else if (cmd_ack) begin
                  en_q  <= 4'b1000;
                  ack_q <= ack_bit;
                  ph    <= PH_ACK;
               end
            end
            default: begin
               if (!tick) begin
                  qcnt <= qcnt + 1'b1;
               end else begin
                  qcnt <= '0;
                  if (qidx != 2'd3) begin
                     qidx <= qidx + 1'b1;
                  end else begin
                     qidx <= '0;
                     case (ph)
                        PH_STOP: begin
                           ph   <= PH_IDLE;
                           en_q <= '0;
                        end
                        PH_DATA: begin
                           if (bidx == BLAST) begin
                              ph   <= PH_HOLD;
                              bf_q <= 1'b0;
                           end else begin
                              bidx  <= bidx + 1'b1;
                              shreg <= {shreg[DATA_W-2:0], 1'b0};
                           end
                        end
                        default: begin
                           ph   <= PH_HOLD;
                           en_q <= '0;
                        end
                     endcase
                  end
               end
            end
         endcase
      end
   end

   assign buf_full  = bf_q;
   assign start_en  = en_q[0];
   assign rstart_en = en_q[1];
   assign stop_en   = en_q[2];
   assign ack_en    = en_q[3];
endmodule

// File: rtl/i2cm_arb_master.sv
module i2cm_arb_master #(
   parameter int DATA_W      = 8,
   parameter int DIV_N       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_drive_low,
   output logic              sda_drive_low,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              buf_full,
   input  logic              cmd_start,
   input  logic              cmd_restart,
   input  logic              cmd_stop,
   input  logic              cmd_ack,
   input  logic              ack_bit,
   output logic              start_en,
   output logic              rstart_en,
   output logic              stop_en,
   output logic              ack_en,
   output logic              coll_irq,
   input  logic              coll_clr,
   output logic              stop_irq,
   input  logic              stop_clr,
   output logic              bus_s,
   output logic              bus_p,
   output logic              bus_free
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (DIV_N < SYNC_STAGES + 1) begin : g_bad_div
         $error("DIV_N must exceed the synchronizer depth");
      end
   endgenerate

   logic scl_s, sda_s, start_det, stop_det, coll;

   i2cm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({scl_in, sda_in}),
      .dout ({scl_s, sda_s})
   );

   i2cm_cond_det u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .start_det(start_det),
      .stop_det (stop_det),
      .bus_s    (bus_s),
      .bus_p    (bus_p)
   );

   assign bus_free = bus_p | ~bus_s;

   i2cm_xmit #(.DATA_W(DATA_W), .DIV_N(DIV_N)) u_xmit (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s      (scl_s),
      .sda_s      (sda_s),
      .bus_free   (bus_free),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .cmd_start  (cmd_start),
      .cmd_restart(cmd_restart),
      .cmd_stop   (cmd_stop),
      .cmd_ack    (cmd_ack),
      .ack_bit    (ack_bit),
      .scl_low    (scl_drive_low),
      .sda_low    (sda_drive_low),
      .buf_full   (buf_full),
      .start_en   (start_en),
      .rstart_en  (rstart_en),
      .stop_en    (stop_en),
      .ack_en     (ack_en),
      .coll       (coll)
   );

   // sticky flags: a new event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coll_irq <= 1'b0;
         stop_irq <= 1'b0;
      end else begin
         if (coll)          coll_irq <= 1'b1;
         else if (coll_clr) coll_irq <= 1'b0;
         if (stop_det)      stop_irq <= 1'b1;
         else if (stop_clr) stop_irq <= 1'b0;
      end
   end
endmodule

// File: rtl/i2cm_arb_master_chk.sv
module i2cm_arb_master_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_drive_low,
   input logic sda_drive_low,
   input logic buf_full,
   input logic start_en,
   input logic rstart_en,
   input logic stop_en,
   input logic ack_en,
   input logic coll_irq,
   input logic stop_irq,
   input logic stop_clr,
   input logic cmd_start,
   input logic bus_free,
   input logic bus_s,
   input logic bus_p
);
   assert_coll_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(coll_irq) |-> (!scl_drive_low && !sda_drive_low && !buf_full));

   assert_coll_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(coll_irq) |-> !(start_en || rstart_en || stop_en || ack_en));

   assert_sp_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_s && bus_p));

   assert_one_seq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_en, rstart_en, stop_en, ack_en}));

   assert_stop_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_irq) |-> bus_p);

   assert_stop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_irq && !stop_clr) |=> stop_irq);

   assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !bus_free && !start_en) |=> !start_en);
endmodule

bind i2cm_arb_master i2cm_arb_master_chk u_chk (.*);

// File: tb/i2cm_arb_master_test.sv
module i2cm_arb_master_test;
   localparam int DW   = 8;
   localparam int DIVN = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, other_sda_low, other_scl_low;
   logic sda_line, scl_line;
   logic scl_drive_low, sda_drive_low, buf_full;
   logic wr_en, cmd_start, cmd_restart, cmd_stop, cmd_ack, ack_bit;
   logic [DW-1:0] wr_data;
   logic start_en, rstart_en, stop_en, ack_en;
   logic coll_irq, coll_clr, stop_irq, stop_clr, bus_s, bus_p, bus_free;

   assign sda_line = !(sda_drive_low || other_sda_low);
   assign scl_line = !(scl_drive_low || other_scl_low);

   i2cm_arb_master #(.DATA_W(DW), .DIV_N(DIVN)) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
      .wr_en(wr_en), .wr_data(wr_data), .buf_full(buf_full),
      .cmd_start(cmd_start), .cmd_restart(cmd_restart), .cmd_stop(cmd_stop),
      .cmd_ack(cmd_ack), .ack_bit(ack_bit),
      .start_en(start_en), .rstart_en(rstart_en), .stop_en(stop_en), .ack_en(ack_en),
      .coll_irq(coll_irq), .coll_clr(coll_clr), .stop_irq(stop_irq), .stop_clr(stop_clr),
      .bus_s(bus_s), .bus_p(bus_p), .bus_free(bus_free)
   );

   int n_cmp = 0, n_bad = 0, cyc = 0;
   always @(posedge clk) cyc++;

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // scoreboard: 256 = START, 512 = STOP, otherwise a byte value
   int exp_q[$];
   task automatic push(int v);
      exp_q.push_back(v);
   endtask

   task automatic sb(int got, string req);
      n_cmp++;
      if (exp_q.size() == 0) begin
         n_bad++;
         $display("FAIL %s scoreboard: actual %0d expected none", req, got);
      end else begin
         int e = exp_q.pop_front();
         if (e != got) begin
            n_bad++;
            $display("FAIL %s scoreboard: actual %0d expected %0d", req, got, e);
         end
      end
   endtask

   // bus monitor
   logic mon_en = 1'b0;
   logic p_scl = 1'b1, p_sda = 1'b1;
   int bitcnt = 0, t_first = 0;
   bit per_done = 1'b0;
   logic [7:0] sh = '0;
   always @(negedge clk) begin
      if (mon_en) begin
         if (p_scl && scl_line && p_sda && !sda_line) begin
            sb(256, "R2 start");
            bitcnt = 0;
         end else if (p_scl && scl_line && !p_sda && sda_line) begin
            sb(512, "R4 stop");
         end else if (!p_scl && scl_line) begin
            if (bitcnt < 8) sh = {sh[6:0], sda_line};
            if (bitcnt == 0) t_first = cyc;
            if (bitcnt == 1 && !per_done) begin
               per_done = 1'b1;
               chk("R10 SCL period", cyc - t_first, 4 * DIVN);
            end
            bitcnt++;
            if (bitcnt == 9) sb(int'(sh), "R3 byte");
         end
      end
      p_scl = scl_line;
      p_sda = sda_line;
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_wr(logic [DW-1:0] d);
      @(negedge clk); wr_data = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   // 0 start, 1 restart, 2 stop, 3 ack
   task automatic cmd(int which);
      @(negedge clk);
      case (which)
         0: cmd_start = 1'b1;
         1: cmd_restart = 1'b1;
         2: cmd_stop = 1'b1;
         default: cmd_ack = 1'b1;
      endcase
      @(negedge clk);
      cmd_start = 1'b0; cmd_restart = 1'b0; cmd_stop = 1'b0; cmd_ack = 1'b0;
   endtask

   task automatic clr_irqs();
      @(negedge clk); coll_clr = 1'b1; stop_clr = 1'b1;
      @(negedge clk); coll_clr = 1'b0; stop_clr = 1'b0;
   endtask

   task automatic wait_quiet(string req);
      int k = 0;
      do begin
         @(negedge clk);
         k++;
      end while ((start_en || rstart_en || stop_en || ack_en || buf_full) && k < 3000);
      if (k >= 3000) chk({req, " sequence timeout"}, 0, 1);
   endtask

   task automatic wait_coll(string req);
      int k = 0;
      while (!coll_irq && k < 500) begin
         @(negedge clk);
         k++;
      end
      if (k >= 500) chk({req, " collision timeout"}, 0, 1);
   endtask

   task automatic wait_scl(bit rise);
      logic p = scl_line;
      for (int k = 0; k < 500; k++) begin
         @(negedge clk);
         if (rise ? (!p && scl_line) : (p && !scl_line)) return;
         p = scl_line;
      end
      chk("R3 SCL edge timeout", 0, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      report();
      $finish;
   end

   initial begin
      rst_n = 1'b0; other_sda_low = 1'b0; other_scl_low = 1'b0;
      wr_en = 1'b0; wr_data = '0; cmd_start = 1'b0; cmd_restart = 1'b0;
      cmd_stop = 1'b0; cmd_ack = 1'b0; ack_bit = 1'b0; coll_clr = 1'b0; stop_clr = 1'b0;
      tick(4);
      rst_n = 1'b1;
      tick(1);

      // reset state
      chk("R1 scl_drive_low", scl_drive_low, 0);
      chk("R1 sda_drive_low", sda_drive_low, 0);
      chk("R1 buf_full", buf_full, 0);
      chk("R1 enables", {start_en, rstart_en, stop_en, ack_en}, 0);
      chk("R1 irqs", {coll_irq, stop_irq}, 0);
      chk("R1 bus_s/bus_p", {bus_s, bus_p}, 0);
      chk("R1 bus_free", bus_free, 1);

      // plain transfer; second write while full is dropped
      mon_en = 1'b1;
      push(256); push(8'hA5); push(512);
      pulse_wr(8'hA5);
      chk("R3 buf_full after write", buf_full, 1);
      pulse_wr(8'h00);
      cmd(0);
      wait_quiet("R3");
      cmd(2);
      wait_quiet("R4");
      chk("R4 lines released after stop", {scl_drive_low, sda_drive_low}, 0);
      chk("R8 stop_irq after own stop", stop_irq, 1);
      chk("R7 bus_p after stop", bus_p, 1);
      chk("R7 bus_s after stop", bus_s, 0);
      chk("R7 bus_free after stop", bus_free, 1);
      clr_irqs();
      chk("R8 stop_irq cleared", stop_irq, 0);

      // repeated start, and a strobe during an active sequence
      push(256); push(8'h3C); push(256); push(8'hC3); push(512);
      pulse_wr(8'h3C);
      @(negedge clk); cmd_start = 1'b1;
      @(negedge clk); cmd_start = 1'b0; cmd_stop = 1'b1;
      @(negedge clk); cmd_stop = 1'b0;
      chk("R2 start_en during start", start_en, 1);
      chk("R11 stop ignored while start runs", stop_en, 0);
      wait_quiet("R3");
      cmd(1);
      wait_quiet("R4");
      pulse_wr(8'hC3);
      wait_quiet("R3");
      cmd(2);
      wait_quiet("R4");
      chk("R4 scoreboard drained", exp_q.size(), 0);
      mon_en = 1'b0;
      clr_irqs();

      // lost arbitration in a data bit
      pulse_wr(8'hFF);
      cmd(0);
      wait_scl(1'b1);
      wait_scl(1'b1);
      wait_scl(1'b0);
      other_sda_low = 1'b1;
      wait_coll("R5");
      chk("R5 coll_irq", coll_irq, 1);
      chk("R5 lines released", {scl_drive_low, sda_drive_low}, 0);
      chk("R5 buf_full cleared", buf_full, 0);
      tick(5);
      other_sda_low = 1'b0;
      tick(6);
      chk("R8 stop_irq from other master", stop_irq, 1);
      chk("R7 bus_p from other stop", bus_p, 1);
      chk("R7 bus_free from other stop", bus_free, 1);
      chk("R8 coll_irq held", coll_irq, 1);

      // fresh byte after the collision starts at its MSB
      clr_irqs();
      mon_en = 1'b1;
      push(256); push(8'h96); push(512);
      pulse_wr(8'h96);
      cmd(0);
      wait_quiet("R9");
      cmd(2);
      wait_quiet("R9");
      chk("R9 scoreboard drained", exp_q.size(), 0);
      mon_en = 1'b0;

      // START refused while another master owns the bus
      clr_irqs();
      other_sda_low = 1'b1;
      tick(6);
      chk("R7 bus_s from other start", bus_s, 1);
      chk("R7 bus_free low while busy", bus_free, 0);
      cmd(0);
      tick(20);
      chk("R2 start_en stays low while busy", start_en, 0);
      chk("R2 lines untouched while busy", {scl_drive_low, sda_drive_low}, 0);
      other_sda_low = 1'b0;
      tick(6);
      chk("R7 bus_free after other stop", bus_free, 1);

      // collision inside START
      clr_irqs();
      @(negedge clk); cmd_start = 1'b1; other_sda_low = 1'b1;
      @(negedge clk); cmd_start = 1'b0;
      wait_coll("R6");
      chk("R6 start aborted", start_en, 0);
      chk("R6 lines released after start collision", {scl_drive_low, sda_drive_low}, 0);
      other_sda_low = 1'b0;
      tick(6);

      // collision inside an acknowledge of '1'
      clr_irqs();
      cmd(0);
      wait_quiet("R6");
      @(negedge clk); other_sda_low = 1'b1; ack_bit = 1'b1;
      cmd(3);
      wait_coll("R6");
      chk("R6 ack aborted", ack_en, 0);
      chk("R6 lines released after ack collision", {scl_drive_low, sda_drive_low}, 0);
      other_sda_low = 1'b0; ack_bit = 1'b0;
      tick(6);

      // collision inside STOP
      clr_irqs();
      cmd(0);
      wait_quiet("R6");
      @(negedge clk); other_sda_low = 1'b1;
      cmd(2);
      wait_coll("R6");
      chk("R6 stop aborted", stop_en, 0);
      chk("R6 lines released after stop collision", {scl_drive_low, sda_drive_low}, 0);
      other_sda_low = 1'b0;
      tick(6);

      // flag clears are independent
      chk("R8 coll_irq before clear", coll_irq, 1);
      @(negedge clk); coll_clr = 1'b1;
      @(negedge clk); coll_clr = 1'b0;
      chk("R8 coll_irq cleared", coll_irq, 0);
      chk("R8 stop_irq kept", stop_irq, 1);

      report();
      $finish;
   end
endmodule